// File: doc/BRIEF.md
# Calendar Real-Time Clock with Second Trim

This block keeps the time of day and the calendar in seven binary registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A one-cycle enable `tick_i`, pulsed once per second by logic outside the block, advances the time. Each advance carries through every field, using the true month lengths and a leap rule of divisibility by four.

A host reaches the registers through a simple single-cycle bus. Every write to a time register or to the trim register is protected. It is taken only if the write just before it on the bus was a write to the unlock address. Writes to other targets on the same bus, flagged by `bus_sel_i` low, also use up the unlock. The trim register holds one of two corrections, which act on the next seconds tick. One adds an extra second and the other removes one, so clock drift can be corrected without rewriting the time.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads seconds 0, minutes 0, hours 0, day of week 1, date 1, month 1, year 0, and the trim register reads 0.
- R2: Each cycle with `tick_i` high and no pending trim advances seconds by one. Without `tick_i` or an accepted write, no register changes.
- R3: Seconds roll over from 59 to 0 and minutes from 59 to 0, each carrying into the next field. Hours roll over from 23 to 0, carrying into the day.
- R4: Day of week (1 = Sunday) rises by one at each midnight and wraps from 7 to 1.
- R5: Date rolls over to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February, advancing the month. Month 12 rolls over to 1 and advances the year, and year 99 rolls over to 0.
- R6: February has 29 days when the year is a multiple of 4, year 0 included, and 28 days otherwise.
- R7: The bus addresses are: seconds 0, minutes 1, hours 2, day of week 3, date 4, month 5, year 6, trim 7, unlock 15. A write with `bus_sel_i` high to addresses 0 to 7 is accepted only when the previous bus write was to address 15 with `bus_sel_i` high. Otherwise it is ignored.
- R8: Any bus write, including one with `bus_sel_i` low, clears the unlock. A later protected write then needs a new unlock.
- R9: An accepted trim write with only bit 0 set holds an increment, which reads back as trim bit 0. The next tick then advances the time by two seconds with full carry and clears the hold.
- R10: An accepted trim write with only bit 1 set holds a decrement, which reads back as trim bit 1. The next tick leaves the time unchanged and clears the hold, and later ticks count normally.
- R11: A trim write with both bits set holds nothing. A trim write made while a correction is already held is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle seconds enable |
| bus_we_i | input | 1 | Bus write strobe, for any target |
| bus_sel_i | input | 1 | Write or read is aimed at this block |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, zero-extended |

## Verification
The counting chain is tested from several start points. One is a plain mid-minute count. One sits one second before a midnight that also crosses a day of week of 7. Others sit on the last day of a 30-day month, a 31-day month, December of year 99, and February of leap years 0 and 24 and of common year 23. These separate a carry that stops at the right field from one that runs on too far or stops short. The unlock is tested three ways: a bare write, an unlock-then-write, and an unlock used up by a write to another target. The trim is tested with increment across a full carry, with decrement, with both bits set, and with a second trim while one is held. These show whether the correction is stored, applied once, and then cleared.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int DOW_W  = 3;
  localparam int DATE_W = 5;
  localparam int MON_W  = 4;
  localparam int YR_W   = 7;

  typedef struct packed {
    logic [YR_W-1:0]   yr;
    logic [MON_W-1:0]  mon;
    logic [DATE_W-1:0] date;
    logic [DOW_W-1:0]  dow;
    logic [HR_W-1:0]   hr;
    logic [MIN_W-1:0]  mn;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC    = 4'd0,
    A_MIN    = 4'd1,
    A_HR     = 4'd2,
    A_DOW    = 4'd3,
    A_DATE   = 4'd4,
    A_MON    = 4'd5,
    A_YR     = 4'd6,
    A_TRIM   = 4'd7,
    A_UNLOCK = 4'd15
  } reg_addr_e;

  localparam cal_time_t TIME_RST = '{
    yr: '0, mon: MON_W'(1), date: DATE_W'(1), dow: DOW_W'(1),
    hr: '0, mn: '0, sec: '0
  };

  function automatic logic [DATE_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                 input logic [YR_W-1:0]  yr);
    logic [DATE_W-1:0] len;
    case (mon)
      MON_W'(2): len = (yr[1:0] == 2'b00) ? DATE_W'(29) : DATE_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): len = DATE_W'(30);
      default: len = DATE_W'(31);
    endcase
    return len;
  endfunction
endpackage

// File: rtl/cal_rtc_unlock.sv
module cal_rtc_unlock
  import cal_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_sel_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              armed_o
);
  logic armed_q;
  logic unlock_wr;

  assign unlock_wr = bus_we_i && bus_sel_i && (bus_addr_i == A_UNLOCK);

  // any bus write re-decides the arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (bus_we_i) armed_q <= unlock_wr;
  end

  assign armed_o = armed_q;

  a_r8_arm_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_sel_i) |=> !armed_o);
  a_r8_arm_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(armed_o));
endmodule

// File: rtl/cal_rtc_trim.sv
module cal_rtc_trim
  import cal_rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       trim_wr_i,
  input  logic [1:0] trim_data_i,
  output logic       inc_o,
  output logic       dec_o
);
  logic inc_q, dec_q;
  logic idle;

  assign idle = !inc_q && !dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else if (tick_i) begin
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else if (trim_wr_i && idle) begin
      // both bits together cancel
      inc_q <= (trim_data_i == 2'b01);
      dec_q <= (trim_data_i == 2'b10);
    end
  end

  assign inc_o = inc_q;
  assign dec_o = dec_q;

  a_r11_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_o && dec_o));
  a_r11_both_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_wr_i && trim_data_i == 2'b11 && !tick_i) |=> $stable({inc_o, dec_o}));
  a_r9_cleared_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !inc_o && !dec_o);
endmodule

// File: rtl/cal_rtc_counter.sv
module cal_rtc_counter
  import cal_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output cal_time_t         time_o
);
  cal_time_t t_q;
  cal_time_t one_step, two_step;

  function automatic cal_time_t step(input cal_time_t t);
    cal_time_t n;
    n = t;
    if (t.sec < SEC_W'(59)) n.sec = t.sec + 1'b1;
    else begin
      n.sec = '0;
      if (t.mn < MIN_W'(59)) n.mn = t.mn + 1'b1;
      else begin
        n.mn = '0;
        if (t.hr < HR_W'(23)) n.hr = t.hr + 1'b1;
        else begin
          n.hr  = '0;
          n.dow = (t.dow >= DOW_W'(7)) ? DOW_W'(1) : t.dow + 1'b1;
          if (t.date < month_len(t.mon, t.yr)) n.date = t.date + 1'b1;
          else begin
            n.date = DATE_W'(1);
            if (t.mon < MON_W'(12)) n.mon = t.mon + 1'b1;
            else begin
              n.mon = MON_W'(1);
              n.yr  = (t.yr >= YR_W'(99)) ? '0 : t.yr + 1'b1;
            end
          end
        end
      end
    end
    return n;
  endfunction

  assign one_step = step(t_q);
  assign two_step = step(one_step);

  // accepted write wins over a coincident tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t_q <= TIME_RST;
    else if (ld_i) begin
      case (ld_addr_i)
        A_SEC:   t_q.sec  <= ld_data_i[SEC_W-1:0];
        A_MIN:   t_q.mn   <= ld_data_i[MIN_W-1:0];
        A_HR:    t_q.hr   <= ld_data_i[HR_W-1:0];
        A_DOW:   t_q.dow  <= ld_data_i[DOW_W-1:0];
        A_DATE:  t_q.date <= ld_data_i[DATE_W-1:0];
        A_MON:   t_q.mon  <= ld_data_i[MON_W-1:0];
        A_YR:    t_q.yr   <= ld_data_i[YR_W-1:0];
        default: ;
      endcase
    end else if (tick_i) begin
      if (dec_i)      t_q <= t_q;
      else if (inc_i) t_q <= two_step;
      else            t_q <= one_step;
    end
  end

  assign time_o = t_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> $stable(time_o));
  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && !inc_i && !dec_i && time_o.sec == SEC_W'(59)) |=> time_o.sec == '0);
  a_r10_dec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && dec_i) |=> $stable(time_o));
  a_r4_dow_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && !dec_i && time_o.dow == DOW_W'(7) && time_o.hr == HR_W'(23)
     && time_o.mn == MIN_W'(59) && time_o.sec == SEC_W'(59)) |=> time_o.dow == DOW_W'(1));
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic              bus_sel_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic      armed;
  logic      prot_wr;
  logic      time_ld;
  logic      trim_wr;
  logic      inc_pend, dec_pend;
  cal_time_t cur;

  assign prot_wr = bus_we_i && bus_sel_i && armed && (bus_addr_i <= A_TRIM);
  assign time_ld = prot_wr && (bus_addr_i != A_TRIM);
  assign trim_wr = prot_wr && (bus_addr_i == A_TRIM);

  cal_rtc_unlock i_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_sel_i  (bus_sel_i),
    .bus_addr_i (bus_addr_i),
    .armed_o    (armed)
  );

  cal_rtc_trim i_trim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .trim_wr_i   (trim_wr),
    .trim_data_i (bus_wdata_i[1:0]),
    .inc_o       (inc_pend),
    .dec_o       (dec_pend)
  );

  cal_rtc_counter i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .inc_i     (inc_pend),
    .dec_i     (dec_pend),
    .ld_i      (time_ld),
    .ld_addr_i (bus_addr_i),
    .ld_data_i (bus_wdata_i),
    .time_o    (cur)
  );

  always_comb begin
    case (bus_addr_i)
      A_SEC:   bus_rdata_o = DATA_W'(cur.sec);
      A_MIN:   bus_rdata_o = DATA_W'(cur.mn);
      A_HR:    bus_rdata_o = DATA_W'(cur.hr);
      A_DOW:   bus_rdata_o = DATA_W'(cur.dow);
      A_DATE:  bus_rdata_o = DATA_W'(cur.date);
      A_MON:   bus_rdata_o = DATA_W'(cur.mon);
      A_YR:    bus_rdata_o = DATA_W'(cur.yr);
      A_TRIM:  bus_rdata_o = DATA_W'({dec_pend, inc_pend});
      default: bus_rdata_o = '0;
    endcase
  end

  a_r7_locked_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !armed && !tick_i) |=> $stable(cur) && $stable({inc_pend, dec_pend}));
  a_r7_unsel_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_sel_i && !tick_i) |=> $stable(cur));
endmodule

// File: tb/test_cal_rtc.sv
module test_cal_rtc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic       bus_sel_i = 1'b0;
  logic [3:0] bus_addr_i = 4'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  cal_rtc i_cal_rtc (
    .clk_i, .rst_ni, .tick_i, .bus_we_i, .bus_sel_i,
    .bus_addr_i, .bus_wdata_i, .bus_rdata_o
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_sel_i = sel; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_sel_i = 1'b0;
  endtask

  task automatic uwr(input logic [3:0] a, input logic [7:0] d);
    wr(4'd15, 8'd0, 1'b1);
    wr(a, d, 1'b1);
  endtask

  task automatic set_time(input int hr, input int mn, input int sec, input int dow,
                          input int dt, input int mo, input int yr);
    uwr(4'd0, 8'(sec)); uwr(4'd1, 8'(mn)); uwr(4'd2, 8'(hr)); uwr(4'd3, 8'(dow));
    uwr(4'd4, 8'(dt));  uwr(4'd5, 8'(mo)); uwr(4'd6, 8'(yr));
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input int exp);
    bus_addr_i = a;
    #1;
    n_chk++;
    if (bus_rdata_o !== 8'(exp)) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, a, bus_rdata_o, exp);
    end
  endtask

  task automatic chk_time(input string req, input int hr, input int mn, input int sec,
                          input int dow, input int dt, input int mo, input int yr);
    chk(req, 4'd0, sec); chk(req, 4'd1, mn); chk(req, 4'd2, hr); chk(req, 4'd3, dow);
    chk(req, 4'd4, dt);  chk(req, 4'd5, mo); chk(req, 4'd6, yr);
  endtask

  task automatic t_reset();
    chk_time("R1", 0, 0, 0, 1, 1, 1, 0);
    chk("R1", 4'd7, 0);
  endtask

  task automatic t_count();
    tick(); tick(); tick();
    chk("R2", 4'd0, 3);
    repeat (5) @(negedge clk_i);
    chk("R2", 4'd0, 3);
  endtask

  task automatic t_midnight();
    set_time(23, 59, 59, 7, 15, 6, 10);
    tick();
    chk_time("R3", 0, 0, 0, 1, 16, 6, 10);
    chk("R4", 4'd3, 1);
    set_time(10, 59, 59, 3, 5, 6, 10);
    tick();
    chk_time("R3", 11, 0, 0, 3, 5, 6, 10);
  endtask

  task automatic t_months();
    set_time(23, 59, 59, 2, 30, 4, 10);
    tick();
    chk("R5", 4'd4, 1); chk("R5", 4'd5, 5);
    set_time(23, 59, 59, 2, 30, 5, 10);
    tick();
    chk("R5", 4'd4, 31); chk("R5", 4'd5, 5);
    set_time(23, 59, 59, 5, 31, 12, 99);
    tick();
    chk_time("R5", 0, 0, 0, 6, 1, 1, 0);
  endtask

  task automatic t_leap();
    set_time(23, 59, 59, 1, 28, 2, 24);
    tick();
    chk("R6", 4'd4, 29); chk("R6", 4'd5, 2);
    set_time(23, 59, 59, 1, 29, 2, 24);
    tick();
    chk("R6", 4'd4, 1); chk("R6", 4'd5, 3);
    set_time(23, 59, 59, 1, 28, 2, 23);
    tick();
    chk("R6", 4'd4, 1); chk("R6", 4'd5, 3);
    set_time(23, 59, 59, 1, 28, 2, 0);
    tick();
    chk("R6", 4'd4, 29); chk("R6", 4'd5, 2);
  endtask

  task automatic t_unlock();
    set_time(1, 2, 3, 4, 5, 6, 7);
    wr(4'd0, 8'd40, 1'b1);
    chk("R7", 4'd0, 3);
    wr(4'd7, 8'd1, 1'b1);
    chk("R7", 4'd7, 0);
    wr(4'd15, 8'd0, 1'b1);
    repeat (3) @(negedge clk_i);
    wr(4'd0, 8'd40, 1'b1);
    chk("R7", 4'd0, 40);
    wr(4'd15, 8'd0, 1'b1);
    wr(4'd2, 8'd9, 1'b0);
    wr(4'd0, 8'd50, 1'b1);
    chk("R8", 4'd0, 40);
    chk("R8", 4'd2, 1);
  endtask

  task automatic t_inc();
    set_time(23, 59, 58, 3, 31, 12, 99);
    uwr(4'd7, 8'h01);
    chk("R9", 4'd7, 1);
    tick();
    chk_time("R9", 0, 0, 0, 4, 1, 1, 0);
    chk("R9", 4'd7, 0);
  endtask

  task automatic t_dec();
    set_time(5, 5, 20, 2, 10, 3, 5);
    uwr(4'd7, 8'h02);
    chk("R10", 4'd7, 2);
    tick();
    chk("R10", 4'd0, 20);
    chk("R10", 4'd7, 0);
    tick();
    chk("R10", 4'd0, 21);
  endtask

  task automatic t_both();
    set_time(5, 5, 30, 2, 10, 3, 5);
    uwr(4'd7, 8'h03);
    chk("R11", 4'd7, 0);
    tick();
    chk("R11", 4'd0, 31);
    uwr(4'd7, 8'h01);
    uwr(4'd7, 8'h02);
    chk("R11", 4'd7, 1);
    tick();
    chk("R11", 4'd0, 33);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_count();
    t_midnight();
    t_months();
    t_leap();
    t_unlock();
    t_inc();
    t_dec();
    t_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule